// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write PHY management registers over a two-wire serial management bus (clause 22 framing). The host sees two 16-bit registers behind a small register port. One is a command word that carries a self-clearing busy flag, the transfer direction, a clock-range select and the target PHY and register numbers. The other holds the data, which is the value to send on a write or the value returned on a read.

The host sets the busy bit in the command word to start a transfer. The block derives the management clock from the system clock with the selected divide ratio. It shifts a complete frame out on the data pin, and the pin is split into output, output enable and input. On reads, the block samples the PHY's answer. When the frame has finished, busy drops, and for a read the returned value is already in the data register at that point. Command writes that arrive while a transfer is running are discarded.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command register (host_addr 0) is laid out as bit 0 busy, bit 1 write (1 = write, 0 = read), bits 5:2 clock-range select, bits 10:6 PHY register number, bits 15:11 PHY address. A command write with bit 0 set while idle starts a transfer, and the readback shows busy = 1 while the transfer runs.
- R2: Busy clears by itself once the last frame bit has completed. The other command fields read back unchanged afterwards.
- R3: A write frame is, MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then the 16-bit value that was in the data register (host_addr 1) when the transfer started. The output enable stays high for all 64 bits.
- R4: A read frame uses opcode 10. The output enable is high for bits 0 to 45 and low for the two turnaround bits and the 16 data bits (bits 46 to 63).
- R5: On a read, the 16 bits sampled on the last 16 rising MDC edges (MSB first) are in the data register by the time busy reads 0.
- R6: The MDC period in system clocks is 16, 26, 42, 62, 102 and 124 for select codes 0 to 5. Codes 6 to 15 give 124.
- R7: mdio_o and mdio_oe change only when MDC falls. Both stay constant while MDC is high.
- R8: While no transfer is active, MDC is low and mdio_oe is low. A command write with bit 0 clear starts no transfer.
- R9: Command writes during an active transfer are ignored: neither the frame nor the stored command fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 16 | Register write value |
| host_rdata | output | 16 | Read value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data to the pad |
| mdio_oe | output | 1 | Pad drive enable |
| mdio_i | input | 1 | Serial data from the pad |

## Verification
On every cycle, the assertions check four things: the pad is quiet and MDC is low whenever busy is clear; the data pin holds steady through each MDC high phase; the pin is driven for the whole of a write and released through the turnaround and data of a read; and command writes made during a transfer leave the stored fields unchanged. They also tie the fall of busy to the frame engine's completion and the data register update to the captured read bits. Only the bench scenarios can show that the bit order is right for particular PHY and register numbers, that the MDC period matches each select code (including the codes that fall back to the default), and that a PHY's reply ends up in the data register.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 4;
    localparam int HALF_W = 7;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;
    localparam logic [1:0] TA_READ  = 2'b11;

    // Field order follows the command word bit layout, MSB to LSB.
    typedef struct packed {
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regn;
        logic [SEL_W-1:0]  sel;
        logic              wr;
        logic              busy;
    } cmd_t;

    // Half of the MDC period, in system clocks, for each select code.
    function automatic logic [HALF_W-1:0] mdc_half(input logic [SEL_W-1:0] sel);
        case (sel)
            4'd0:    return HALF_W'(8);
            4'd1:    return HALF_W'(13);
            4'd2:    return HALF_W'(21);
            4'd3:    return HALF_W'(31);
            4'd4:    return HALF_W'(51);
            default: return HALF_W'(62);
        endcase
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt;
    logic              wrap;

    assign wrap = run && (cnt == half - HALF_W'(1));
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    // R6: the half-period counter never passes its limit
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt < half);
    // R8: the clock parks low as soon as the engine stops
    a_r8_mdc_parks_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_wr,
    input  logic [PHY_AW-1:0] phy,
    input  logic [REG_AW-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdc_lvl,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
    localparam int DAT_POS   = FRAME_LEN - DATA_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] frame_w;
    logic [FRAME_LEN-1:0] tx_sr;
    logic [DATA_W-1:0]    rx_sr;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     idx_nxt;
    logic                 wr_q;

    always_comb begin
        frame_w = {{PRE_LEN{1'b1}}, SOF_BITS, (is_wr ? OP_WRITE : OP_READ),
                   phy, regn, (is_wr ? TA_WRITE : TA_READ),
                   (is_wr ? wdata : {DATA_W{1'b1}})};
    end

    assign idx_nxt = idx + IDX_W'(1);
    assign mdio_o  = tx_sr[FRAME_LEN-1];
    assign done    = active && fall && (idx == LAST);
    assign rdata   = rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            idx     <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            mdio_oe <= 1'b0;
            wr_q    <= 1'b0;
        end else if (start && !active) begin
            active  <= 1'b1;
            idx     <= '0;
            tx_sr   <= frame_w;
            mdio_oe <= 1'b1;
            wr_q    <= is_wr;
        end else if (active) begin
            if (rise && idx >= IDX_W'(DAT_POS))
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (idx == LAST) begin
                    active  <= 1'b0;
                    mdio_oe <= 1'b0;
                end else begin
                    idx     <= idx_nxt;
                    tx_sr   <= tx_sr << 1;
                    mdio_oe <= wr_q || (idx_nxt < IDX_W'(TA_POS));
                end
            end
        end
    end

    // R7: pin values hold through the MDC high phase
    a_r7_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc_lvl && $past(mdc_lvl)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R3: a write frame drives the pin throughout
    a_r3_write_driven: assert property (@(posedge clk) disable iff (rst)
        (active && wr_q) |-> mdio_oe);
    // R4: a read frame releases the pin from the turnaround onward
    a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
        (active && !wr_q && idx >= IDX_W'(TA_POS)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    cmd_t              cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              start;
    logic              eng_active;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              tick_rise;
    logic              tick_fall;

    assign accept = host_wr && !host_addr && !cmd_q.busy;
    assign start  = accept && host_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept)
                cmd_q <= cmd_t'(host_wdata);
            if (host_wr && host_addr)
                data_q <= host_wdata;
            if (eng_done) begin
                cmd_q.busy <= 1'b0;
                if (!cmd_q.wr)
                    data_q <= eng_rdata;
            end
        end
    end

    assign host_rdata = host_addr ? data_q : 16'(cmd_q);

    mdio_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_active),
        .half (mdc_half(cmd_q.sel)),
        .mdc  (mdc),
        .rise (tick_rise),
        .fall (tick_fall)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .is_wr   (host_wdata[1]),
        .phy     (host_wdata[15:11]),
        .regn    (host_wdata[10:6]),
        .wdata   (data_q),
        .mdc_lvl (mdc),
        .rise    (tick_rise),
        .fall    (tick_fall),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .active  (eng_active),
        .done    (eng_done),
        .rdata   (eng_rdata)
    );

    // R8: no clock and no drive while idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_q.busy |-> (!mdio_oe && !mdc));
    // R9: stored fields survive a command write during a transfer
    a_r9_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.busy && host_wr && !host_addr) |=>
        ($stable(cmd_q.phy) && $stable(cmd_q.regn) && $stable(cmd_q.sel) && $stable(cmd_q.wr)));
    // R2: busy drops only when the frame engine finishes
    a_r2_busy_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_q.busy) |-> $past(eng_done));
    // R5: the read result lands with the completion
    a_r5_read_capture: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !cmd_q.wr) |=> (data_q == $past(eng_rdata)));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    logic    cap_o  [0:63];
    logic    cap_oe [0:63];
    int      rise_n = 0;
    realtime t_rise [0:1];
    int      glitch = 0;
    logic [15:0] phy_rdata = '0;

    always #5 clk = !clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY-side monitor: record each bit at the rising MDC edge
    always @(posedge mdc) begin
        #1;
        if (rise_n < 64) begin
            cap_o[rise_n]  = mdio_o;
            cap_oe[rise_n] = mdio_oe;
        end
        if (rise_n < 2) t_rise[rise_n] = $realtime;
        rise_n = rise_n + 1;
    end

    // PHY-side responder: present read data after MDC falls
    always @(negedge mdc) begin
        #1;
        if (rise_n >= 48 && rise_n <= 63) mdio_i = phy_rdata[63 - rise_n];
        else mdio_i = 1'b1;
    end

    // R7 observer: pin must match the value seen at the last rise while MDC is high
    always @(negedge clk) begin
        if (mdc && rise_n > 0 && rise_n <= 64) begin
            if (mdio_o !== cap_o[rise_n-1] || mdio_oe !== cap_oe[rise_n-1])
                glitch = glitch + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 20000; i++) begin
            host_read(1'b0, v);
            if (!v[0]) return;
        end
        chk(1'b0, "R2 busy timeout", 1, 0);
    endtask

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
    endfunction

    function automatic int exp_ratio(input logic [3:0] sel);
        case (sel)
            4'd0: return 16;
            4'd1: return 26;
            4'd2: return 42;
            4'd3: return 62;
            4'd4: return 102;
            default: return 124;
        endcase
    endfunction

    function automatic logic [15:0] mk_cmd(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [3:0] sel, input bit wr, input bit busy);
        return {phy, rg, sel, wr, busy};
    endfunction

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [3:0] sel, input logic [15:0] d, output int bad_bits);
        logic [15:0] v;
        logic [63:0] ef;
        rise_n = 0; glitch = 0;
        if (wr) host_write(1'b1, d);
        host_write(1'b0, mk_cmd(phy, rg, sel, wr, 1'b1));
        host_read(1'b0, v);
        chk(v == mk_cmd(phy, rg, sel, wr, 1'b1), "R1 busy set with fields", v, mk_cmd(phy, rg, sel, wr, 1'b1));
        wait_idle();
        host_read(1'b0, v);
        chk(v == mk_cmd(phy, rg, sel, wr, 1'b0), "R2 busy cleared fields kept", v, mk_cmd(phy, rg, sel, wr, 1'b0));
        chk(rise_n == 64, "R3 rising edge count", rise_n, 64);
        ef = exp_frame(wr, phy, rg, d);
        bad_bits = 0;
        for (int i = 0; i < 64; i++) begin
            if (wr || i < 46) begin
                if (cap_oe[i] !== 1'b1 || cap_o[i] !== ef[63-i]) bad_bits++;
            end else begin
                if (cap_oe[i] !== 1'b0) bad_bits++;
            end
        end
        chk(glitch == 0, "R7 pin steady while MDC high", glitch, 0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        host_read(1'b0, v);
        chk(v == 16'h0, "R1 command reset value", v, 0);
        host_read(1'b1, v);
        chk(v == 16'h0, "R5 data reset value", v, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle pins after reset", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        int bad;
        run_frame(1'b1, phy, rg, 4'd0, d, bad);
        chk(bad == 0, "R3 write frame bits", bad, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle after write", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
        int bad;
        logic [15:0] v;
        phy_rdata = val;
        run_frame(1'b0, phy, rg, 4'd0, 16'h0, bad);
        chk(bad == 0, "R4 read frame bits and release", bad, 0);
        host_read(1'b1, v);
        chk(v == val, "R5 read data captured", v, val);
    endtask

    task automatic t_divider(input logic [3:0] sel);
        int bad;
        int per;
        phy_rdata = 16'h1234;
        run_frame(1'b0, 5'd1, 5'd2, sel, 16'h0, bad);
        per = int'((t_rise[1] - t_rise[0]) / 10.0);
        chk(per == exp_ratio(sel), "R6 MDC period", per, exp_ratio(sel));
    endtask

    task automatic t_ignore();
        logic [15:0] v;
        logic [63:0] ef;
        int bad;
        rise_n = 0;
        host_write(1'b1, 16'hA5C3);
        host_write(1'b0, mk_cmd(5'd9, 5'd17, 4'd0, 1'b1, 1'b1));
        repeat (60) @(negedge clk);
        host_write(1'b0, mk_cmd(5'd30, 5'd1, 4'd5, 1'b0, 1'b1));
        host_read(1'b0, v);
        chk(v == mk_cmd(5'd9, 5'd17, 4'd0, 1'b1, 1'b1), "R9 command kept during transfer", v, mk_cmd(5'd9, 5'd17, 4'd0, 1'b1, 1'b1));
        wait_idle();
        ef = exp_frame(1'b1, 5'd9, 5'd17, 16'hA5C3);
        bad = 0;
        for (int i = 0; i < 64; i++)
            if (cap_oe[i] !== 1'b1 || cap_o[i] !== ef[63-i]) bad++;
        chk(bad == 0 && rise_n == 64, "R9 frame unaffected", bad, 0);
        repeat (300) @(negedge clk);
        chk(rise_n == 64, "R9 no second frame", rise_n, 64);
    endtask

    task automatic t_no_busy();
        logic [15:0] v;
        rise_n = 0;
        host_write(1'b0, mk_cmd(5'd4, 5'd6, 4'd0, 1'b1, 1'b0));
        repeat (300) @(negedge clk);
        chk(rise_n == 0 && mdio_oe == 1'b0, "R8 no transfer without busy", rise_n, 0);
        host_read(1'b0, v);
        chk(v == mk_cmd(5'd4, 5'd6, 4'd0, 1'b1, 1'b0), "R1 fields stored while idle", v, mk_cmd(5'd4, 5'd6, 4'd0, 1'b1, 1'b0));
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write(5'd3, 5'd0, 16'h8001);
        t_write(5'd31, 5'd21, 16'h5A3C);
        t_read(5'd1, 5'd2, 16'hBEEF);
        t_read(5'd16, 5'd31, 16'h0001);
        t_divider(4'd0);
        t_divider(4'd1);
        t_divider(4'd3);
        t_divider(4'd5);
        t_divider(4'd9);
        t_ignore();
        t_no_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule